// File: doc/BRIEF.md
# Quad-Nibble Security ID Read Responder

This block is the target side of a four-wire serial flash link, limited to one transaction: reading a small factory identification area. The host pulls chip select low and clocks in a one-byte opcode and a one-byte start address, four bits per clock. It then gives four idle clocks. After that the responder drives the identification bytes back, four bits per clock, advancing its own read pointer.

SCK, chip select and the data lines are sampled by a faster local clock `clk`, and SCK edges are found by comparing each sample with the one before it. The ID contents are loaded through a simple synchronous write port before any read. When the pointer passes the highest valid ID location, the responder keeps sending zero bytes rather than wrapping back to location 0. Raising chip select ends any transaction at once.

Top module: `sid_quad_responder`

## Requirements
- R1: While `ce_n` is low, the first two SCK rising edges capture an opcode from `sio_in`, high nibble first. Opcode 88h selects the ID read.
- R2: The next two rising edges capture the start address, high nibble first. Four more rising edges follow as dummy clocks. `sio_oe` stays 0 throughout these eight header clocks.
- R3: The first data nibble is driven on the SCK falling edge that follows the eighth rising edge. A new nibble is driven on every later falling edge, with the high nibble of each byte before its low nibble.
- R4: The first byte returned is the one at the start address. The pointer then advances by one after each complete byte.
- R5: The byte at `LAST_ADDR` is followed by 00h bytes until chip select rises. If the start address is above `LAST_ADDR`, 00h bytes are returned from the start.
- R6: A clock of `clk` that samples `ce_n` high clears `sio_oe` to 0 on that edge and returns the header decoder to the opcode stage, whatever phase was active. This holds even when an SCK falling edge is seen in the same clock.
- R7: With any opcode other than 88h, `sio_oe` stays 0 for the rest of the transaction. The next transaction decodes normally.
- R8: The block behaves the same whether SCK idles low (mode 0) or high (mode 3) while `ce_n` is high.
- R9: While `pre_we` is 1, each `clk` edge writes `pre_data` into ID location `pre_addr`. A later read returns that value.
- R10: While `rst_n` is 0, each `clk` edge clears `sio_oe` and `sio_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock, several times faster than SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| ce_n | input | 1 | Active-low chip select |
| sio_in | input | 4 | Incoming nibble lines |
| pre_we | input | 1 | ID memory write strobe |
| pre_addr | input | 8 | ID memory write location |
| pre_data | input | 8 | ID memory write value |
| sio_out | output | 4 | Outgoing nibble lines |
| sio_oe | output | 1 | Drive enable for `sio_out` |

## Verification
Two events can land in the same `clk` cycle: an SCK falling edge that would advance the output, and chip select rising to end the transaction. The bench provokes this by lowering SCK and raising chip select on the same local clock, in the middle of a data stream. It then requires `sio_oe` to be 0 on the next sample, and requires a fresh transaction to start from the opcode. A second coincidence also occurs: the low nibble of the byte at `LAST_ADDR` is driven on the same edge that switches the stream to zero fill. Vectors that cross the end of the ID area judge this by expecting 00h from the very next byte.

// File: rtl/sid_pkg.sv
`timescale 1ns/1ps
// Shared constants and the header phase type for the security ID responder.
package sid_pkg;
    localparam int NIB_W        = 4;
    localparam int BYTE_W       = 8;
    localparam int ADDR_W       = BYTE_W;
    localparam int ID_DEPTH     = 2 ** ADDR_W;
    localparam int HDR_NIBBLES  = 8;
    localparam int HDR_CNT_W    = $clog2(HDR_NIBBLES);
    localparam logic [BYTE_W-1:0] CMD_READ_SID = 8'h88;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_IGNORE
    } sid_phase_e;
endpackage

// File: rtl/sid_hdr_decoder.sv
`timescale 1ns/1ps
// Header decoder: counts SCK rising edges while selected, assembles the
// opcode and start address from nibble pairs, and walks the dummy clocks.
// Assumes sck/ce_n/sio_in are already synchronous to clk.
module sid_hdr_decoder
    import sid_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                rise,
    input  logic [NIB_W-1:0]    sio_in,
    output sid_phase_e          phase,
    output logic [ADDR_W-1:0]   start_addr,
    output logic                hdr_done
);
    localparam logic [HDR_CNT_W-1:0] HDR_LAST = HDR_CNT_W'(HDR_NIBBLES - 1);

    logic [HDR_CNT_W-1:0] cnt;
    logic [NIB_W-1:0]     hi_nib;

    // Pulse on the last dummy rising edge: the data phase begins.
    assign hdr_done = rise && (phase == PH_DUMMY) && (cnt == HDR_LAST);

    // Header state: opcode, address and dummy tracking per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_n) begin
            phase      <= PH_CMD;
            cnt        <= '0;
            hi_nib     <= '0;
            start_addr <= '0;
        end else if (rise) begin
            case (phase)
                PH_CMD: begin
                    cnt <= cnt + 1'b1;
                    if (!cnt[0])
                        hi_nib <= sio_in;
                    else if ({hi_nib, sio_in} == CMD_READ_SID)
                        phase <= PH_ADDR;
                    else
                        phase <= PH_IGNORE;
                end
                PH_ADDR: begin
                    cnt <= cnt + 1'b1;
                    if (!cnt[0]) begin
                        hi_nib <= sio_in;
                    end else begin
                        start_addr <= {hi_nib, sio_in};
                        phase      <= PH_DUMMY;
                    end
                end
                PH_DUMMY: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == HDR_LAST)
                        phase <= PH_DATA;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sid_id_store.sv
`timescale 1ns/1ps
// ID storage: one synchronous write port for preloading and one
// asynchronous read port for the output driver. Contents are not reset.
module sid_id_store
    import sid_pkg::*;
(
    input  logic                clk,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [BYTE_W-1:0]   rd_data
);
    logic [BYTE_W-1:0] mem [ID_DEPTH];

    // Preload write.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/sid_nibble_driver.sv
`timescale 1ns/1ps
// Output driver: holds the read pointer and emits one nibble per SCK falling
// edge during the data phase, high nibble first. After the byte at
// LAST_ADDR it emits zeros until deselected.
module sid_nibble_driver
    import sid_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LAST_ADDR = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                fall,
    input  logic                in_data,
    input  logic                load,
    input  logic [ADDR_W-1:0]   load_addr,
    input  logic [BYTE_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   rd_addr,
    output logic [NIB_W-1:0]    sio_out,
    output logic                sio_oe,
    output logic                exhausted
);
    logic                lo_next;
    logic [BYTE_W-1:0]   cur_byte;

    assign cur_byte = exhausted ? '0 : rd_data;

    // Pointer, nibble select, zero-fill flag and output register.
    always_ff @(posedge clk) begin
        if (!rst_n || ce_n) begin
            rd_addr   <= '0;
            lo_next   <= 1'b0;
            exhausted <= 1'b0;
            sio_out   <= '0;
            sio_oe    <= 1'b0;
        end else if (load) begin
            rd_addr   <= load_addr;
            lo_next   <= 1'b0;
            exhausted <= (load_addr > LAST_ADDR);
        end else if (fall && in_data) begin
            sio_oe  <= 1'b1;
            sio_out <= lo_next ? cur_byte[NIB_W-1:0] : cur_byte[BYTE_W-1:NIB_W];
            lo_next <= ~lo_next;
            if (lo_next) begin
                if (rd_addr == LAST_ADDR)
                    exhausted <= 1'b1;
                else
                    rd_addr <= rd_addr + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sid_quad_responder.sv
`timescale 1ns/1ps
// Top of the security ID read responder. Oversamples SCK with clk to find
// its edges, decodes the header, and streams ID bytes as nibbles.
// Assumes SCK is at most a quarter of the clk rate and inputs are synchronous.
module sid_quad_responder
    import sid_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LAST_ADDR = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck,
    input  logic                ce_n,
    input  logic [NIB_W-1:0]    sio_in,
    input  logic                pre_we,
    input  logic [ADDR_W-1:0]   pre_addr,
    input  logic [BYTE_W-1:0]   pre_data,
    output logic [NIB_W-1:0]    sio_out,
    output logic                sio_oe
);
    logic                sck_q;
    logic                rise_edge;
    logic                fall_edge;
    sid_phase_e          phase;
    logic [ADDR_W-1:0]   start_addr;
    logic                hdr_done;
    logic [ADDR_W-1:0]   rd_addr;
    logic [BYTE_W-1:0]   rd_data;
    logic                exhausted;

    // Previous SCK sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sck_q <= sck;
        else
            sck_q <= sck;
    end

    assign rise_edge = sck & ~sck_q;
    assign fall_edge = ~sck & sck_q;

    sid_hdr_decoder u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .rise       (rise_edge),
        .sio_in     (sio_in),
        .phase      (phase),
        .start_addr (start_addr),
        .hdr_done   (hdr_done)
    );

    sid_id_store u_store (
        .clk     (clk),
        .wr_en   (pre_we),
        .wr_addr (pre_addr),
        .wr_data (pre_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    sid_nibble_driver #(.LAST_ADDR(LAST_ADDR)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .fall      (fall_edge),
        .in_data   (phase == PH_DATA),
        .load      (hdr_done),
        .load_addr (start_addr),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .sio_out   (sio_out),
        .sio_oe    (sio_oe),
        .exhausted (exhausted)
    );
endmodule

// File: rtl/sid_quad_responder_chk.sv
`timescale 1ns/1ps
// Property checker for the responder, attached to every instance by bind.
module sid_quad_responder_chk
    import sid_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                fall_edge,
    input  sid_phase_e          phase,
    input  logic                exhausted,
    input  logic [NIB_W-1:0]    sio_out,
    input  logic                sio_oe
);
    // R2: no drive before the data phase.
    a_r2_quiet_header: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMD || phase == PH_ADDR || phase == PH_DUMMY) |-> !sio_oe);

    // R3: the output only moves on an SCK falling edge.
    a_r3_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_edge && !ce_n) |=> $stable(sio_out));

    // R5: zero fill once the ID area is used up.
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted && fall_edge && phase == PH_DATA && !ce_n) |=> (sio_out == '0));

    // R6: deselect removes the drive.
    a_r6_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !sio_oe);

    // R7: a foreign opcode never drives.
    a_r7_foreign_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> !sio_oe);

    // R10: reset clears the outputs.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!sio_oe && sio_out == '0));
endmodule

bind sid_quad_responder sid_quad_responder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .fall_edge (fall_edge),
    .phase     (phase),
    .exhausted (exhausted),
    .sio_out   (sio_out),
    .sio_oe    (sio_oe)
);

// File: tb/sid_quad_responder_tb.sv
`timescale 1ns/1ps
module sid_quad_responder_tb;
    localparam logic [7:0] TB_LAST = 8'd39;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       ce_n = 1'b1;
    logic [3:0] sio_in = '0;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic [3:0] sio_out;
    logic       sio_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] tb_mem [256];

    always #2.5 clk = ~clk;

    sid_quad_responder #(.LAST_ADDR(TB_LAST)) u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .ce_n(ce_n), .sio_in(sio_in),
        .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
        .sio_out(sio_out), .sio_oe(sio_oe)
    );

    // Vector: {mode3, opcode, start address, byte count}
    localparam logic [24:0] VEC [8] = '{
        {1'b0, 8'h88, 8'h00, 8'd4},
        {1'b1, 8'h88, 8'h10, 8'd3},
        {1'b0, 8'h88, 8'h25, 8'd5},
        {1'b1, 8'h88, 8'h27, 8'd3},
        {1'b0, 8'h88, 8'h50, 8'd2},
        {1'b0, 8'h0B, 8'h00, 8'd3},
        {1'b1, 8'h89, 8'h05, 8'd2},
        {1'b0, 8'h88, 8'h1F, 8'd2}
    };

    function automatic logic [7:0] exp_byte(input int a);
        return (a <= int'(TB_LAST)) ? tb_mem[a] : 8'h00;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_nib(input logic [3:0] nib);
        sck = 1'b0; sio_in = nib; clks(HALF);
        sck = 1'b1; clks(HALF);
    endtask

    task automatic get_nib(output logic [3:0] o, output logic oe);
        sck = 1'b0; clks(HALF);
        o = sio_out; oe = sio_oe;
        sck = 1'b1; clks(HALF);
    endtask

    task automatic begin_txn(input logic mode3, input logic [7:0] cmd, input logic [7:0] addr);
        sck = mode3; clks(HALF);
        ce_n = 1'b0; clks(HALF);
        send_nib(cmd[7:4]); send_nib(cmd[3:0]);
        check("R1 quiet after opcode", {7'd0, sio_oe}, 8'd0);
        send_nib(addr[7:4]); send_nib(addr[3:0]);
        for (int d = 0; d < 4; d++) send_nib(4'h0);
        check("R2 quiet after header", {7'd0, sio_oe}, 8'd0);
    endtask

    task automatic end_txn(input logic mode3);
        ce_n = 1'b1; clks(2);
        check("R6 oe off after deselect", {7'd0, sio_oe}, 8'd0);
        sck = mode3; clks(HALF);
    endtask

    task automatic run_txn(input logic [24:0] v);
        logic [3:0] hi, lo;
        logic       oh, ol;
        logic       m3;
        logic [7:0] cmd, addr, nb;
        {m3, cmd, addr, nb} = v;
        begin_txn(m3, cmd, addr);
        for (int b = 0; b < int'(nb); b++) begin
            get_nib(hi, oh);
            get_nib(lo, ol);
            if (cmd == 8'h88) begin
                check(m3 ? "R3 R4 R5 R8 byte mode3" : "R3 R4 R5 R8 byte mode0",
                      {hi, lo}, exp_byte(int'(addr) + b));
                check("R3 oe during data", {6'd0, oh, ol}, 8'd3);
            end else begin
                check("R7 foreign opcode silent", {6'd0, oh, ol}, 8'd0);
            end
        end
        end_txn(m3);
    endtask

    // Watchdog: a hung run is a failure that still reports.
    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [3:0] o;
        logic       oe;
        for (int a = 0; a < 256; a++) tb_mem[a] = 8'((a * 37 + 11) ^ 8'h5A) | 8'h01;

        clks(3);
        check("R10 reset oe", {7'd0, sio_oe}, 8'd0);
        check("R10 reset out", {4'd0, sio_out}, 8'd0);
        rst_n = 1'b1;
        clks(2);

        // Preload the ID area.
        for (int a = 0; a < 256; a++) begin
            pre_we = 1'b1; pre_addr = 8'(a); pre_data = tb_mem[a];
            clks(1);
        end
        pre_we = 1'b0;
        clks(2);

        // Vector table.
        for (int i = 0; i < 8; i++) run_txn(VEC[i]);

        // R9: rewrite one location and read it back.
        pre_we = 1'b1; pre_addr = 8'h03; pre_data = 8'hC6; clks(1);
        pre_we = 1'b0; tb_mem[3] = 8'hC6; clks(2);
        begin_txn(1'b0, 8'h88, 8'h03);
        get_nib(o, oe); check("R9 rewritten hi", {4'd0, o}, 8'h0C);
        get_nib(o, oe); check("R9 rewritten lo", {4'd0, o}, 8'h06);
        end_txn(1'b0);

        // R6: abort in the header, then a clean transaction.
        sck = 1'b0; clks(HALF); ce_n = 1'b0; clks(HALF);
        send_nib(4'h8); send_nib(4'h8); send_nib(4'h0);
        end_txn(1'b0);
        run_txn({1'b0, 8'h88, 8'h02, 8'd2});

        // R6: deselect on the same clock as an SCK falling edge mid-data.
        begin_txn(1'b0, 8'h88, 8'h07);
        get_nib(o, oe); check("R6 first nibble before abort", {4'd0, o}, {4'd0, tb_mem[7][7:4]});
        @(negedge clk); sck = 1'b0; ce_n = 1'b1;
        clks(2);
        check("R6 collide deselect oe", {7'd0, sio_oe}, 8'd0);
        clks(HALF);
        run_txn({1'b0, 8'h88, 8'h08, 8'd1});

        // R10: reset in the data phase.
        begin_txn(1'b1, 8'h88, 8'h01);
        get_nib(o, oe); check("R10 drive before reset", {7'd0, oe}, 8'd1);
        rst_n = 1'b0; clks(2);
        check("R10 reset mid-data oe", {7'd0, sio_oe}, 8'd0);
        check("R10 reset mid-data out", {4'd0, sio_out}, 8'd0);
        ce_n = 1'b1; rst_n = 1'b1; clks(HALF);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule